// File: doc/BRIEF.md
# Power-Gated Two-Unit ALU with Isolated Inputs and Retained Results

This block is a 16-bit ALU built as two units that can be switched off one at a time. The arithmetic unit and the logical unit each get both operands at once. Each unit has its own power enable, an input isolation control, and a result register with shadow storage that can be saved and restored. A unit-select input chooses which unit's result reaches the single merged output. A unit that is switched off adds nothing to that output.

Power-off is modelled at register-transfer level. While a unit is off, its result register is overwritten every cycle with a fixed corruption pattern (alternating `10` bit pairs, `16'hAAAA` at the default width). The shadow storage is always on, so it keeps its contents. The register can return to a known value in three ways: a restore from a valid save, a fresh load, or a reset. Supplies, level shifting and voltage states are not modelled.

Top module: `dual_domain_alu`

## Requirements
- R1: While `rst_n` is low, `result` is 0. Reset also clears both result registers and marks both shadows as holding no saved value.
- R2: In an arithmetic unit that is powered, not isolated and not restoring, the result register loads at each clock edge the value selected by `arith_op`. The codes are: 000 A+B, 001 A-B, 010 the low 16 bits of A*B, 011 A/B, 100 A+1, 101 A-1. Codes 110 and 111 give 0. The new value shows on `result` after that edge when `pick_logic`=0.
- R3: Arithmetic code 011 with B=0 gives 16'hFFFF.
- R4: In a logical unit that is powered, not isolated and not restoring, the result register loads the value selected by `logic_op`. The codes are: 0000 A&B, 0001 A|B, 0010 A^B, 0011 ~(A^B), 0100 ~A, 0101 A shifted left by 1, 0110 A shifted right by 1 with a 0 filled in. Codes 0111 to 1111 give 0. The value shows on `result` when `pick_logic`=1.
- R5: While a powered unit's isolation input is high and it is not restoring, its result register holds its value and operand changes have no effect.
- R6: While the unit chosen by `pick_logic` is unpowered, `result` is 0.
- R7: Each clock edge with a unit's power low writes the corruption pattern into its result register. After power returns, the pattern is visible until a restore, a load or a reset.
- R8: A save pulse while the unit is powered copies the current result register into its shadow. A later restore while powered loads that exact value.
- R9: A restore with no save since reset leaves the result register unchanged, so it still shows the corruption pattern. The next load replaces it.
- R10: A save pulse while the unit is unpowered is ignored, and the shadow keeps its earlier contents.
- R11: `pick_logic`=0 routes the arithmetic register to `result`, and 1 routes the logical register. Switching it changes no stored state.
- R12: When restore and a non-isolated load happen in the same cycle, restore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | 16 | Operand A, shared by both units |
| opb | input | 16 | Operand B, shared by both units |
| arith_op | input | 3 | Arithmetic operation code |
| logic_op | input | 4 | Logical operation code |
| pick_logic | input | 1 | 0 selects the arithmetic result, 1 selects the logical result |
| arith_pwr | input | 1 | Arithmetic unit power enable (1 = on) |
| logic_pwr | input | 1 | Logical unit power enable (1 = on) |
| arith_iso | input | 1 | Arithmetic input isolation |
| logic_iso | input | 1 | Logical input isolation |
| arith_save | input | 1 | Arithmetic save pulse |
| logic_save | input | 1 | Logical save pulse |
| arith_restore | input | 1 | Arithmetic restore pulse |
| logic_restore | input | 1 | Logical restore pulse |
| result | output | 16 | Merged result |

## Verification
Directed operand pairs test the corner values of each operation:
- a divisor of zero
- a product that overflows
- bit patterns whose top and bottom bits show which way a shift went

Directed power sequences separate the retention paths from one another:
- save, then power-off, then restore, which must give the exact saved value
- restore with no save, which must leave the corruption pattern
- save while off, which must leave the older shadow in place

Seeded random cycles vary power, isolation, save and restore per unit, including unused opcodes. A bench model then tells apart restore priority, hold under isolation and output clamping in combinations the directed cases do not reach.

// File: rtl/dda_pkg.sv
package dda_pkg;
   typedef enum logic [2:0] {
      AR_ADD = 3'd0, AR_SUB = 3'd1, AR_MUL = 3'd2,
      AR_DIV = 3'd3, AR_INC = 3'd4, AR_DEC = 3'd5
   } arith_code_e;

   typedef enum logic [3:0] {
      LG_AND = 4'd0, LG_OR  = 4'd1, LG_XOR = 4'd2, LG_XNOR = 4'd3,
      LG_NOTA = 4'd4, LG_SHL = 4'd5, LG_SHR = 4'd6
   } logic_code_e;

   localparam int ARITH_SEL_W = 3;
   localparam int LOGIC_SEL_W = 4;
   localparam int NUM_DOMAINS = 2;
endpackage

// File: rtl/pd_arith_core.sv
module pd_arith_core
   import dda_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [ARITH_SEL_W-1:0] op_i,
   input  logic [WIDTH-1:0]       a_i,
   input  logic [WIDTH-1:0]       b_i,
   output logic [WIDTH-1:0]       y_o
);
   localparam logic [WIDTH-1:0]   ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0]   ZERO = '0;
   logic [2*WIDTH-1:0]            prod;

   assign prod = {ZERO, a_i} * {ZERO, b_i};

   always_comb begin
      case (op_i)
         AR_ADD:  y_o = a_i + b_i;
         AR_SUB:  y_o = a_i - b_i;
         AR_MUL:  y_o = prod[WIDTH-1:0];
         AR_DIV:  y_o = (b_i == ZERO) ? '1 : a_i / b_i;
         AR_INC:  y_o = a_i + ONE;
         AR_DEC:  y_o = a_i - ONE;
         default: y_o = '0;
      endcase
   end

   always_comb begin
      if (op_i == AR_DIV && b_i == ZERO)
         assert_div_zero_R3: assert (&y_o);
   end
endmodule

// File: rtl/pd_logic_core.sv
module pd_logic_core
   import dda_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [LOGIC_SEL_W-1:0] op_i,
   input  logic [WIDTH-1:0]       a_i,
   input  logic [WIDTH-1:0]       b_i,
   output logic [WIDTH-1:0]       y_o
);
   always_comb begin
      case (op_i)
         LG_AND:  y_o = a_i & b_i;
         LG_OR:   y_o = a_i | b_i;
         LG_XOR:  y_o = a_i ^ b_i;
         LG_XNOR: y_o = ~(a_i ^ b_i);
         LG_NOTA: y_o = ~a_i;
         LG_SHL:  y_o = {a_i[WIDTH-2:0], 1'b0};
         LG_SHR:  y_o = {1'b0, a_i[WIDTH-1:1]};
         default: y_o = '0;
      endcase
   end

   always_comb begin
      if (op_i == LG_SHL)
         assert_shl_lsb_R4: assert (y_o[0] == 1'b0);
   end
endmodule

// File: rtl/pd_retention_reg.sv
module pd_retention_reg #(
   parameter int               WIDTH   = 16,
   parameter logic [WIDTH-1:0] CORRUPT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_i,
   input  logic             iso_i,
   input  logic             save_i,
   input  logic             restore_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] shadow;
   logic             saved;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o    <= '0;
         shadow <= '0;
         saved  <= 1'b0;
      end else begin
         if (!pwr_i)
            q_o <= CORRUPT;
         else if (restore_i) begin
            if (saved) q_o <= shadow;
         end else if (!iso_i)
            q_o <= d_i;
         if (pwr_i && save_i) begin
            shadow <= q_o;
            saved  <= 1'b1;
         end
      end
   end

   assert_off_corrupt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_i |=> (q_o == CORRUPT));
   assert_iso_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_i && iso_i && !restore_i) |=> $stable(q_o));
   assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_i && restore_i && saved) |=> (q_o == $past(shadow)));
   assert_restore_nosave_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_i && restore_i && !saved) |=> $stable(q_o));
   assert_save_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_i) |=> $stable(shadow));
endmodule

// File: rtl/dual_domain_alu.sv
module dual_domain_alu
   import dda_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIDTH-1:0]       opa,
   input  logic [WIDTH-1:0]       opb,
   input  logic [ARITH_SEL_W-1:0] arith_op,
   input  logic [LOGIC_SEL_W-1:0] logic_op,
   input  logic                   pick_logic,
   input  logic                   arith_pwr,
   input  logic                   logic_pwr,
   input  logic                   arith_iso,
   input  logic                   logic_iso,
   input  logic                   arith_save,
   input  logic                   logic_save,
   input  logic                   arith_restore,
   input  logic                   logic_restore,
   output logic [WIDTH-1:0]       result
);
   localparam logic [WIDTH-1:0] CORRUPT_PAT = {(WIDTH/2){2'b10}};

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("dual_domain_alu: WIDTH must be even and at least 4");
   end

   logic [NUM_DOMAINS-1:0] pwr_v, iso_v, save_v, rest_v;
   logic [WIDTH-1:0]       core_y [NUM_DOMAINS];
   logic [WIDTH-1:0]       reg_q  [NUM_DOMAINS];

   assign pwr_v  = {logic_pwr,     arith_pwr};
   assign iso_v  = {logic_iso,     arith_iso};
   assign save_v = {logic_save,    arith_save};
   assign rest_v = {logic_restore, arith_restore};

   for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
      logic [WIDTH-1:0] a_cl, b_cl;
      assign a_cl = iso_v[d] ? '0 : opa;
      assign b_cl = iso_v[d] ? '0 : opb;

      if (d == 0) begin : g_arith
         pd_arith_core #(.WIDTH(WIDTH)) u_core (
            .op_i(arith_op), .a_i(a_cl), .b_i(b_cl), .y_o(core_y[d]));
      end else begin : g_logic
         pd_logic_core #(.WIDTH(WIDTH)) u_core (
            .op_i(logic_op), .a_i(a_cl), .b_i(b_cl), .y_o(core_y[d]));
      end

      pd_retention_reg #(.WIDTH(WIDTH), .CORRUPT(CORRUPT_PAT)) u_ret (
         .clk(clk), .rst_n(rst_n), .pwr_i(pwr_v[d]), .iso_i(iso_v[d]),
         .save_i(save_v[d]), .restore_i(rest_v[d]),
         .d_i(core_y[d]), .q_o(reg_q[d]));
   end

   always_comb begin
      if (pick_logic)
         result = logic_pwr ? reg_q[1] : '0;
      else
         result = arith_pwr ? reg_q[0] : '0;
   end

   assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pick_logic && !logic_pwr) || (!pick_logic && !arith_pwr)) |-> (result == '0));
   assert_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_logic && logic_pwr) |-> (result == reg_q[1]));
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (reg_q[0] == '0 && reg_q[1] == '0));
endmodule

// File: tb/dual_domain_alu_test.sv
module dual_domain_alu_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] opa, opb;
   logic [2:0]  arith_op;
   logic [3:0]  logic_op;
   logic        pick_logic;
   logic        arith_pwr, logic_pwr, arith_iso, logic_iso;
   logic        arith_save, logic_save, arith_restore, logic_restore;
   logic [15:0] result;

   int n_chk  = 0;
   int n_fail = 0;
   localparam logic [15:0] CPAT = 16'hAAAA;

   logic [15:0] m_q  [2];
   logic [15:0] m_sh [2];
   logic        m_sv [2];

   always #10 clk = ~clk;

   dual_domain_alu uut (
      .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
      .arith_op(arith_op), .logic_op(logic_op), .pick_logic(pick_logic),
      .arith_pwr(arith_pwr), .logic_pwr(logic_pwr),
      .arith_iso(arith_iso), .logic_iso(logic_iso),
      .arith_save(arith_save), .logic_save(logic_save),
      .arith_restore(arith_restore), .logic_restore(logic_restore),
      .result(result));

   function automatic logic [15:0] arith_ref(logic [2:0] op, logic [15:0] a, logic [15:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a * b;
         3'd3: return (b == 0) ? 16'hFFFF : a / b;
         3'd4: return a + 16'd1;
         3'd5: return a - 16'd1;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] logic_ref(logic [3:0] op, logic [15:0] a, logic [15:0] b);
      case (op)
         4'd0: return a & b;
         4'd1: return a | b;
         4'd2: return a ^ b;
         4'd3: return ~(a ^ b);
         4'd4: return ~a;
         4'd5: return a << 1;
         4'd6: return a >> 1;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: result=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_dom(int d, logic pwr, logic iso, logic sv, logic rs, logic [15:0] v);
      logic [15:0] old_q = m_q[d];
      if (!pwr) m_q[d] = CPAT;
      else if (rs) begin if (m_sv[d]) m_q[d] = m_sh[d]; end
      else if (!iso) m_q[d] = v;
      if (pwr && sv) begin m_sh[d] = old_q; m_sv[d] = 1'b1; end
   endtask

   task automatic step();
      logic [15:0] ca, cl, ea;
      string tag;
      @(posedge clk);
      if (!rst_n) begin
         for (int d = 0; d < 2; d++) begin m_q[d] = 0; m_sh[d] = 0; m_sv[d] = 0; end
      end else begin
         ca = arith_ref(arith_op, opa, opb);
         cl = logic_ref(logic_op, opa, opb);
         model_dom(0, arith_pwr, arith_iso, arith_save, arith_restore, ca);
         model_dom(1, logic_pwr, logic_iso, logic_save, logic_restore, cl);
      end
      @(negedge clk);
      if (!rst_n) begin ea = 0; tag = "R1"; end
      else if (pick_logic) begin
         ea = logic_pwr ? m_q[1] : 16'h0;
         tag = !logic_pwr ? "R6" : (logic_iso ? "R5" : "R4");
      end else begin
         ea = arith_pwr ? m_q[0] : 16'h0;
         tag = !arith_pwr ? "R6" : (arith_iso ? "R5" : "R2");
      end
      chk({tag, " model"}, result, ea);
   endtask

   task automatic idle_ctl();
      arith_pwr = 1; logic_pwr = 1; arith_iso = 0; logic_iso = 0;
      arith_save = 0; logic_save = 0; arith_restore = 0; logic_restore = 0;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; opa = 16'h5555; opb = 16'h3333; arith_op = 0; logic_op = 0;
      pick_logic = 0; idle_ctl();
      step(); step();
      chk("R1 reset", result, 16'h0000);
      rst_n = 1;

      // R2 arithmetic directed
      opa = 16'h1234; opb = 16'h0101; arith_op = 3'd0; step();
      chk("R2 add", result, 16'h1335);
      opa = 16'h0123; opb = 16'h0010; arith_op = 3'd2; step();
      chk("R2 mul", result, 16'h1230);
      opa = 16'h8000; opb = 16'h0004; step();
      chk("R2 mul overflow", result, 16'h0000);
      opa = 16'd100; opb = 16'd7; arith_op = 3'd3; step();
      chk("R2 div", result, 16'd14);
      opb = 16'd0; step();
      chk("R3 div zero", result, 16'hFFFF);
      opa = 16'h0000; arith_op = 3'd5; step();
      chk("R2 dec wrap", result, 16'hFFFF);
      arith_op = 3'd7; step();
      chk("R2 unused code", result, 16'h0000);

      // R4 logical directed
      pick_logic = 1;
      opa = 16'h00FF; opb = 16'h0F0F; logic_op = 4'd3; step();
      chk("R4 xnor", result, 16'hF00F);
      opa = 16'h8001; logic_op = 4'd5; step();
      chk("R4 shl", result, 16'h0002);
      logic_op = 4'd6; step();
      chk("R4 shr", result, 16'h4000);

      // R5 isolation holds
      logic_iso = 1; opa = 16'hFFFF; logic_op = 4'd4; step();
      chk("R5 iso hold", result, 16'h4000);

      // R8 save, power off, restore
      logic_save = 1; step(); logic_save = 0;
      logic_pwr = 0; step();
      chk("R6 clamp off", result, 16'h0000);
      logic_pwr = 1; step();
      chk("R7 corrupt visible", result, CPAT);
      logic_restore = 1; step(); logic_restore = 0;
      chk("R8 restore exact", result, 16'h4000);
      logic_iso = 0;

      // R11 routing: arith holds FFFF-independent value
      pick_logic = 0; opa = 16'h0010; opb = 16'h0001; arith_op = 3'd1;
      logic_iso = 1; step();
      chk("R11 arith routed", result, 16'h000F);
      arith_iso = 1; pick_logic = 1; step();
      chk("R11 logic routed", result, 16'h4000);
      pick_logic = 0; step();
      chk("R11 no state change", result, 16'h000F);

      // R9 restore without save
      arith_pwr = 0; step();
      arith_pwr = 1; arith_restore = 1; step(); arith_restore = 0;
      chk("R9 no save keeps corrupt", result, CPAT);
      arith_iso = 0; arith_op = 3'd4; opa = 16'h0041; step();
      chk("R9 reload after corrupt", result, 16'h0042);

      // R10 save while off ignored
      arith_save = 1; step(); arith_save = 0;           // shadow = 0042
      opa = 16'h0099; step();                           // q = 009A
      chk("R2 inc", result, 16'h009A);
      arith_pwr = 0; arith_save = 1; step(); arith_save = 0;
      arith_pwr = 1; arith_iso = 1; arith_restore = 1; step(); arith_restore = 0;
      chk("R10 save while off", result, 16'h0042);

      // R12 restore beats load
      arith_iso = 0; opa = 16'h7000; arith_op = 3'd0; opb = 16'h0001; step();
      chk("R12 pre-load", result, 16'h7001);
      arith_restore = 1; step(); arith_restore = 0;
      chk("R12 restore priority", result, 16'h0042);

      // random phase
      for (int i = 0; i < 600; i++) begin
         opa = 16'($urandom); opb = 16'($urandom);
         if ($urandom_range(0, 7) == 0) opb = 16'h0000;
         arith_op = 3'($urandom); logic_op = 4'($urandom);
         pick_logic = 1'($urandom);
         arith_pwr = ($urandom_range(0, 5) != 0);
         logic_pwr = ($urandom_range(0, 5) != 0);
         arith_iso = ($urandom_range(0, 3) == 0);
         logic_iso = ($urandom_range(0, 3) == 0);
         arith_save = ($urandom_range(0, 4) == 0);
         logic_save = ($urandom_range(0, 4) == 0);
         arith_restore = ($urandom_range(0, 4) == 0);
         logic_restore = ($urandom_range(0, 4) == 0);
         step();
      end

      rst_n = 0; step();
      chk("R1 final reset", result, 16'h0000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule